// File: doc/BRIEF.md
# Burst Beat Sequencer and Long-Word Address Generator

This block sits between a processor bus and a DRAM strobe sequencer. When a transfer starts, it reads the transfer-burst flag and the 3-bit size field and works out how many long-word beats the transfer needs: one, two or eight. It captures the low long-word address bits once, at the start strobe. After that it produces the address of every beat itself, because the processor holds the address constant for the whole transfer.

The DRAM sequencer moves the block forward with a one-cycle advance pulse. With two banks installed, beats go out back to back, and bit 0 of each beat address picks the bank, so successive beats alternate between banks. With only one bank installed, the block puts a pause step between beats so that the single bank can recover. It flags the final beat, and the advance taken on that beat sends it back to idle.

The sequencer has three states, changed by these transitions:
- `ST_IDLE` goes to `ST_BEAT` on *accept*: the start strobe is sampled while idle.
- `ST_BEAT` stays in `ST_BEAT` on *next-beat*: advance on a non-final beat with two banks.
- `ST_BEAT` goes to `ST_PAUSE` on *recover*: advance on a non-final beat with one bank.
- `ST_PAUSE` goes to `ST_BEAT` on *resume*: advance while pausing.
- `ST_BEAT` goes to `ST_IDLE` on *finish*: advance on the final beat.

With advance low, every state holds.

Top module: `beat_burst_ctrl`

## Requirements
- R1: During and after reset, with no transfer started, `beat_valid_o`, `pause_o` and `last_o` are all 0.
- R2: The beat count is decided as follows. Burst flag low (asserted) with size 3'b011 gives 8 beats. Burst flag high with size 3'b100 gives 2 beats. Every other combination of the two inputs gives 1 beat.
- R3: `dbl_n_o` is 0 exactly when the burst flag is high and the size is 3'b100, and is 1 otherwise. It follows the inputs combinationally.
- R4: Suppose a start strobe is sampled while idle. In the following cycle, `beat_valid_o` is 1 and `beat_addr_o` equals the captured `addr_lo_i`.
- R5: Beat i of an N-beat transfer starting from address B has this address: its bits above log2(N) are those of B, and its low log2(N) bits are (B + i) mod N.
- R6: `bank_sel_o` equals bit 0 of the current beat address. In dual-bank mode, consecutive beats of a transfer therefore alternate banks.
- R7: In single-bank mode (`single_bank_i` = 1 at the start strobe), each advance on a non-final beat leads to one pause step. In a pause step, `pause_o` is 1 and `beat_valid_o` is 0. The next advance presents the following beat. In dual-bank mode no pause step occurs.
- R8: While `advance_i` is 0, the current step holds. The beat address, bank select, last flag and pause request all keep their values.
- R9: `last_o` is 1 together with the final beat's address and only then. An advance on the final beat returns the block to idle in the next cycle.
- R10: A start strobe sampled while a transfer is in progress has no effect on the beats being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer start strobe |
| tbst_n_i | input | 1 | Transfer-burst flag, active low |
| size_i | input | 3 | Transfer size field |
| addr_lo_i | input | IDX_W (3) | Low long-word address bits at start |
| single_bank_i | input | 1 | 1 = one bank installed, 0 = two banks |
| advance_i | input | 1 | Beat-advance pulse from the DRAM sequencer |
| beat_valid_o | output | 1 | A beat is being presented |
| beat_addr_o | output | IDX_W (3) | Long-word address of the current beat |
| bank_sel_o | output | 1 | Bank used by the current beat |
| pause_o | output | 1 | Pause step requested between beats |
| last_o | output | 1 | Current beat is the final one |
| dbl_n_o | output | 1 | Double-beat indicator, active low |

## Verification
The assertions assume that `advance_i` comes only from the DRAM sequencer and is only ever high while a beat or a pause step is active. They also assume the start strobe is meaningful only while idle, so they place no constraint on it during a transfer. The stimulus respects this. It raises advance only after a start has been accepted, and drops it in the cycle that returns the block to idle. The one exception is the R10 case, where the bench pulses start deliberately in the middle of a transfer and then confirms that the beat sequence carries on unchanged.

// File: rtl/beat_pkg.sv
package beat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT  = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        XF_SINGLE = 2'd0,
        XF_DOUBLE = 2'd1,
        XF_BURST  = 2'd2
    } xfer_kind_e;

    localparam logic [2:0] SIZE_LONG  = 3'b011;
    localparam logic [2:0] SIZE_DLONG = 3'b100;

endpackage

// File: rtl/beat_decode.sv
module beat_decode
    import beat_pkg::*;
#(
    parameter int BURST_BEATS = 8,
    parameter int IDX_W       = $clog2(BURST_BEATS)
) (
    input  logic             tbst_n_i,
    input  logic [2:0]       size_i,
    output xfer_kind_e       kind_o,
    output logic [IDX_W-1:0] wrap_mask_o,
    output logic             dbl_n_o
);

    localparam logic [IDX_W-1:0] MASK_BURST  = IDX_W'(BURST_BEATS - 1);
    localparam logic [IDX_W-1:0] MASK_DOUBLE = IDX_W'(1);

    logic is_burst;
    logic is_double;

    always_comb begin
        is_burst  = (tbst_n_i == 1'b0) && (size_i == SIZE_LONG);
        is_double = (tbst_n_i == 1'b1) && (size_i == SIZE_DLONG);
    end

    always_comb begin
        if (is_burst) begin
            kind_o = XF_BURST;
        end else if (is_double) begin
            kind_o = XF_DOUBLE;
        end else begin
            kind_o = XF_SINGLE;
        end
    end

    always_comb begin
        unique case (kind_o)
            XF_BURST:  wrap_mask_o = MASK_BURST;
            XF_DOUBLE: wrap_mask_o = MASK_DOUBLE;
            XF_SINGLE: wrap_mask_o = '0;
            default:   wrap_mask_o = '0;
        endcase
    end

    assign dbl_n_o = ~is_double;

endmodule

// File: rtl/beat_addr_gen.sv
module beat_addr_gen #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] base_i,
    input  logic [IDX_W-1:0] mask_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] addr_o,
    output logic             final_o
);

    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] mask_q;
    logic [IDX_W-1:0] count_q;
    logic [IDX_W-1:0] offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            count_q <= '0;
        end else if (load_i) begin
            base_q  <= base_i;
            mask_q  <= mask_i;
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + IDX_W'(1);
        end
    end

    always_comb begin
        offset  = base_q + count_q;
        addr_o  = (base_q & ~mask_q) | (offset & mask_q);
        final_o = (count_q == mask_q);
    end

endmodule

// File: rtl/beat_seq.sv
module beat_seq
    import beat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic advance_i,
    input  logic single_bank_i,
    input  logic final_i,
    output logic load_o,
    output logic step_o,
    output logic valid_o,
    output logic pause_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       single_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_BEAT;
            end
            ST_BEAT: begin
                if (advance_i) begin
                    if (final_i) begin
                        state_d = ST_IDLE;
                    end else if (single_q) begin
                        state_d = ST_PAUSE;
                    end else begin
                        state_d = ST_BEAT;
                    end
                end
            end
            ST_PAUSE: begin
                if (advance_i) state_d = ST_BEAT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            single_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) single_q <= single_bank_i;
        end
    end

    always_comb begin
        load_o  = 1'b0;
        step_o  = 1'b0;
        valid_o = 1'b0;
        pause_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_BEAT: begin
                valid_o = 1'b1;
                step_o  = advance_i && !final_i && !single_q;
            end
            ST_PAUSE: begin
                pause_o = 1'b1;
                step_o  = advance_i;
            end
            default: begin
                load_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/beat_burst_ctrl.sv
module beat_burst_ctrl
    import beat_pkg::*;
#(
    parameter int BURST_BEATS = 8,
    parameter int IDX_W       = $clog2(BURST_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tbst_n_i,
    input  logic [2:0]       size_i,
    input  logic [IDX_W-1:0] addr_lo_i,
    input  logic             single_bank_i,
    input  logic             advance_i,
    output logic             beat_valid_o,
    output logic [IDX_W-1:0] beat_addr_o,
    output logic             bank_sel_o,
    output logic             pause_o,
    output logic             last_o,
    output logic             dbl_n_o
);

    xfer_kind_e       kind;
    logic [IDX_W-1:0] wrap_mask;
    logic             load;
    logic             step;
    logic             final_beat;
    logic [IDX_W-1:0] cur_addr;

    beat_decode #(
        .BURST_BEATS(BURST_BEATS),
        .IDX_W      (IDX_W)
    ) decode_i (
        .tbst_n_i   (tbst_n_i),
        .size_i     (size_i),
        .kind_o     (kind),
        .wrap_mask_o(wrap_mask),
        .dbl_n_o    (dbl_n_o)
    );

    beat_seq seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .advance_i    (advance_i),
        .single_bank_i(single_bank_i),
        .final_i      (final_beat),
        .load_o       (load),
        .step_o       (step),
        .valid_o      (beat_valid_o),
        .pause_o      (pause_o)
    );

    beat_addr_gen #(
        .IDX_W(IDX_W)
    ) addr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .base_i (addr_lo_i),
        .mask_i (wrap_mask),
        .step_i (step),
        .addr_o (cur_addr),
        .final_o(final_beat)
    );

    assign beat_addr_o = cur_addr;
    assign bank_sel_o  = cur_addr[0];
    assign last_o      = beat_valid_o && final_beat;

endmodule

// File: rtl/beat_burst_chk.sv
module beat_burst_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             advance_i,
    input logic             beat_valid_o,
    input logic [IDX_W-1:0] beat_addr_o,
    input logic             bank_sel_o,
    input logic             pause_o,
    input logic             last_o
);

    // R4: a start sampled while idle presents a beat next cycle
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid_o && !pause_o && start_i) |=> beat_valid_o);

    // R6: consecutive beats alternate banks unless a pause intervenes
    p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && advance_i && !last_o) |=> (pause_o || (beat_valid_o && bank_sel_o != $past(bank_sel_o))));

    // R7: pause step excludes a beat and resumes into a beat
    p_pause_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> !beat_valid_o);
    p_pause_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && advance_i) |=> beat_valid_o);

    // R8: no advance keeps the step unchanged
    p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !advance_i) |=> (beat_valid_o && $stable(beat_addr_o) && $stable(last_o)));
    p_hold_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && !advance_i) |=> pause_o);

    // R9: last flag only on a beat, and the final advance goes idle
    p_last_on_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);
    p_last_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i) |=> (!beat_valid_o && !pause_o));

endmodule

bind beat_burst_ctrl beat_burst_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .advance_i   (advance_i),
    .beat_valid_o(beat_valid_o),
    .beat_addr_o (beat_addr_o),
    .bank_sel_o  (bank_sel_o),
    .pause_o     (pause_o),
    .last_o      (last_o)
);

// File: tb/beat_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module beat_burst_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       tbst_n_i = 1'b1;
    logic [2:0] size_i = 3'd0;
    logic [2:0] addr_lo_i = 3'd0;
    logic       single_bank_i = 1'b0;
    logic       advance_i = 1'b0;
    logic       beat_valid_o;
    logic [2:0] beat_addr_o;
    logic       bank_sel_o;
    logic       pause_o;
    logic       last_o;
    logic       dbl_n_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    beat_burst_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tbst_n_i     (tbst_n_i),
        .size_i       (size_i),
        .addr_lo_i    (addr_lo_i),
        .single_bank_i(single_bank_i),
        .advance_i    (advance_i),
        .beat_valid_o (beat_valid_o),
        .beat_addr_o  (beat_addr_o),
        .bank_sel_o   (bank_sel_o),
        .pause_o      (pause_o),
        .last_o       (last_o),
        .dbl_n_o      (dbl_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_beat(input string req, input int addr, input int last);
        chk({req, " valid"}, int'(beat_valid_o), 1);
        chk({req, " pause"}, int'(pause_o), 0);
        chk({req, " addr"}, int'(beat_addr_o), addr);
        chk({req, " bank"}, int'(bank_sel_o), addr & 1);
        chk({req, " last"}, int'(last_o), last);
    endtask

    task automatic chk_idle(input string req);
        chk({req, " valid"}, int'(beat_valid_o), 0);
        chk({req, " pause"}, int'(pause_o), 0);
        chk({req, " last"}, int'(last_o), 0);
    endtask

    task automatic run_xfer(input int tb, input int sz, input int base, input int sb, input int gap);
        int len;
        int m;
        int ea;
        if (tb == 0 && sz == 3) len = 8;
        else if (tb == 1 && sz == 4) len = 2;
        else len = 1;
        m = len - 1;
        @(negedge clk);
        tbst_n_i = tb[0];
        size_i = sz[2:0];
        addr_lo_i = base[2:0];
        single_bank_i = sb[0];
        start_i = 1'b1;
        advance_i = 1'b0;
        #1;
        chk("R3 dbl_n", int'(dbl_n_o), (tb == 1 && sz == 4) ? 0 : 1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R4 first beat", int'(beat_addr_o), base);
        for (int i = 0; i < len; i++) begin
            ea = (base & ~m & 7) | ((base + i) & m);
            chk_beat("R5 R2 R9 beat", ea, (i == m) ? 1 : 0);
            if (gap != 0 && i == 0) begin
                advance_i = 1'b0;
                start_i = 1'b1;
                addr_lo_i = 3'(base + 3);
                tbst_n_i = 1'b0;
                size_i = 3'b011;
                @(negedge clk);
                start_i = 1'b0;
                chk_beat("R8 R10 hold", ea, (i == m) ? 1 : 0);
            end
            advance_i = 1'b1;
            @(negedge clk);
            if (sb != 0 && i != m) begin
                chk("R7 pause", int'(pause_o), 1);
                chk("R7 no beat", int'(beat_valid_o), 0);
                if (gap != 0) begin
                    advance_i = 1'b0;
                    @(negedge clk);
                    chk("R8 pause hold", int'(pause_o), 1);
                    advance_i = 1'b1;
                end
                @(negedge clk);
            end
        end
        advance_i = 1'b0;
        chk_idle("R9 idle after final");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        chk_idle("R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        for (int tb = 0; tb < 2; tb++) begin
            for (int sz = 0; sz < 8; sz++) begin
                for (int sb = 0; sb < 2; sb++) begin
                    for (int base = 0; base < 8; base++) begin
                        run_xfer(tb, sz, base, sb, (base == 5) ? 1 : 0);
                    end
                end
            end
        end
        @(negedge clk);
        chk_idle("R1 final idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule